// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer with Freeze

This block carries configuration-register writes from a fast bus clock domain into a slow counter clock domain. Each register has a bus-side staging copy. When the write is launched, the value is moved into a transfer holding register. A request toggle crosses to the slow side through two flops. The slow side captures the held value and returns an acknowledge toggle through two flops. Each register has its own busy bit, which is high from the write until the acknowledge has come back.

Holding the freeze input high stops writes from being forwarded, so a group of registers can be loaded in any order. While freeze is high, a register may be rewritten and the last value wins. Dropping freeze launches every staged register on the same bus edge, so the values land together in the slow domain.

If the slow clock source is reported as not selected, staged writes wait. They go out once the source is selected. While freeze is low, a write to a busy register is dropped and sets a sticky error flag.

Top module: `wsync_bridge`

## Requirements
- R1: After reset, all busy bits are 0, the error flag is 0, and every slow-domain register value is 0.
- R2: A write to an idle register while freeze is low sets that register's busy bit, visible after the write edge. When the busy bit falls, the slow-domain value equals the written data.
- R3: A launched write clears its busy bit no sooner than 4 and no later than 40 bus cycles after the launch, with a slow clock of one eighth the bus rate.
- R4: A write affects only the selected register. The busy bits of all other registers stay as they were.
- R5: A write to a busy register while freeze is low is dropped. The error flag rises on the next bus edge, and the slow value becomes the earlier data.
- R6: While freeze is high, writes are staged with busy high, and the slow-domain values do not change.
- R7: Several writes to the same register while frozen raise no error. The last data written is the value committed.
- R8: Dropping freeze launches all staged registers together. Their busy bits fall on the same bus cycle, with the new values present in the slow domain.
- R9: While slow_clk_on_i is low, staged writes stay pending with busy high and the slow values unchanged. They complete after slow_clk_on_i rises.
- R10: The error flag stays set until reset.
- R11: A write whose select value is NUM_REGS or higher has no effect: no busy bit rises and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| wr_sel_i | input | SEL_W | Register index |
| wr_data_i | input | DATA_W | Write data |
| freeze_i | input | 1 | Hold staged writes while high |
| slow_clk_on_i | input | 1 | High when a slow clock source is selected |
| busy_o | output | NUM_REGS | Per-register write-in-flight flags (bus domain) |
| wr_err_o | output | 1 | Sticky flag for a write dropped because its register was busy |
| slow_clk_i | input | 1 | Slow counter clock |
| slow_regs_o | output | NUM_REGS*DATA_W | Synchronized register values, register i at bits i*DATA_W upward |

## Verification
The busy bit and the error flag are due one bus edge after the write. The bench samples every output on the falling bus edge, against a reference model that is updated on the rising edge. The crossing delay depends on the phase of the slow clock, so the bench does not predict it. Instead, each in-flight register is given a window of 4 to 40 bus cycles. The slow value is checked on the first falling edge where that register's busy bit reads low. For a group released from freeze, the bench requires all of the busy bits to fall on that same falling edge.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  localparam int unsigned WS_NUM_REGS = 3;
  localparam int unsigned WS_DATA_W   = 32;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsync_sync2.sv
module wsync_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/wsync_chan.sv
module wsync_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              freeze_i,
  input  logic              clk_on_i,
  output logic              busy_o,
  output logic              reject_o,
  input  logic              slow_clk_i,
  output logic [DATA_W-1:0] slow_val_o
);
  logic [DATA_W-1:0] stage_q, xfer_q, slow_q;
  logic pend_q, fly_q, req_q, seen_q;
  logic req_s, ack_s;
  logic busy, launch, take;

  assign busy     = pend_q | fly_q;
  // launch only when nothing is in flight, so xfer_q is stable while sampled
  assign launch   = pend_q && !fly_q && !freeze_i && clk_on_i;
  assign take     = hit_i && (freeze_i || !busy);
  assign reject_o = hit_i && !freeze_i && busy;
  assign busy_o   = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      xfer_q  <= '0;
      pend_q  <= 1'b0;
      fly_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (launch) begin
        xfer_q <= stage_q;
        req_q  <= ~req_q;
        fly_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (fly_q && (ack_s == req_q)) begin
        fly_q <= 1'b0;
      end
      if (take) begin
        stage_q <= data_i;
        pend_q  <= 1'b1;
      end
    end
  end

  wsync_sync2 u_req_sync (.clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(req_q),  .q_o(req_s));
  wsync_sync2 u_ack_sync (.clk_i(clk_i),      .rst_ni(rst_ni), .d_i(seen_q), .q_o(ack_s));

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= '0;
      seen_q <= 1'b0;
    end else if (req_s != seen_q) begin
      slow_q <= xfer_q;
      seen_q <= req_s;
    end
  end
  assign slow_val_o = slow_q;

  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !busy && !freeze_i) |=> busy_o);
  assert_reject_keeps_stage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !freeze_i && busy) |=> $stable(stage_q));
  assert_frozen_no_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(freeze_i) |-> $stable(req_q));
  assert_no_clk_no_launch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clk_on_i) |-> $stable(req_q));
endmodule

// File: rtl/wsync_bridge.sv
module wsync_bridge
  import wsync_pkg::*;
#(
  parameter int unsigned NUM_REGS = WS_NUM_REGS,
  parameter int unsigned DATA_W   = WS_DATA_W,
  localparam int unsigned SEL_W   = sel_width(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SEL_W-1:0]           wr_sel_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       freeze_i,
  input  logic                       slow_clk_on_i,
  output logic [NUM_REGS-1:0]        busy_o,
  output logic                       wr_err_o,
  input  logic                       slow_clk_i,
  output logic [NUM_REGS*DATA_W-1:0] slow_regs_o
);
  logic [NUM_REGS-1:0] reject;
  logic err_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chan
    logic hit;
    assign hit = wr_en_i && (int'(wr_sel_i) == i);
    wsync_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit),
      .data_i    (wr_data_i),
      .freeze_i  (freeze_i),
      .clk_on_i  (slow_clk_on_i),
      .busy_o    (busy_o[i]),
      .reject_o  (reject[i]),
      .slow_clk_i(slow_clk_i),
      .slow_val_o(slow_regs_o[i*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (|reject)  err_q <= 1'b1;
  end
  assign wr_err_o = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_bad_sel_no_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_sel_i) >= NUM_REGS && !err_q) |=> !err_q);
  assert_reject_sets_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reject) |=> wr_err_o);
endmodule

// File: tb/wsync_bridge_tb.sv
module wsync_bridge_tb;
  localparam int N = 3;
  localparam int W = 32;

  logic clk_i = 0, slow_clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0, freeze_i = 0, slow_clk_on_i = 1;
  logic [1:0] wr_sel_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [N-1:0] busy_o;
  logic wr_err_o;
  logic [N*W-1:0] slow_regs_o;

  int checks = 0, errors = 0;
  string tag = "R4";

  wsync_bridge #(.NUM_REGS(N), .DATA_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .freeze_i(freeze_i), .slow_clk_on_i(slow_clk_on_i),
    .busy_o(busy_o), .wr_err_o(wr_err_o), .slow_clk_i(slow_clk_i),
    .slow_regs_o(slow_regs_o));

  always #2.5 clk_i = ~clk_i;
  initial begin #3; forever #20 slow_clk_i = ~slow_clk_i; end

  // reference model
  bit pend[N], flight[N], m_err;
  logic [W-1:0] stage[N], fval[N], commit[N];
  int age[N];

  function automatic logic [W-1:0] sreg(int i);
    return slow_regs_o[i*W +: W];
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) if (rst_ni) begin
    for (int i = 0; i < N; i++) begin
      bit busyv, hit, lau;
      busyv = pend[i] | flight[i];
      hit   = wr_en_i && (int'(wr_sel_i) == i);
      lau   = pend[i] && !flight[i] && !freeze_i && slow_clk_on_i;
      if (lau) begin flight[i] = 1; pend[i] = 0; fval[i] = stage[i]; age[i] = 0; end
      if (hit) begin
        if (freeze_i || !busyv) begin stage[i] = wr_data_i; pend[i] = 1; end
        else m_err = 1;
      end
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    chk(wr_err_o == m_err, "R5", W'(wr_err_o), W'(m_err));
    for (int i = 0; i < N; i++) begin
      if (pend[i]) chk(busy_o[i] == 1'b1, "R6", W'(busy_o[i]), 1);
      else if (flight[i]) begin
        age[i]++;
        if (!busy_o[i]) begin
          chk(age[i] >= 4 && age[i] <= 40, "R3", W'(age[i]), 40);
          chk(sreg(i) == fval[i], "R2", sreg(i), fval[i]);
          commit[i] = fval[i];
          flight[i] = 0;
        end else if (age[i] > 40) begin
          chk(0, "R3", W'(age[i]), 40);
          flight[i] = 0;
        end
      end else begin
        chk(busy_o[i] == 1'b0, tag, W'(busy_o[i]), 0);
        chk(sreg(i) == commit[i], "R6", sreg(i), commit[i]);
      end
    end
  end

  task automatic wr(int sel, logic [W-1:0] d);
    wr_en_i = 1; wr_sel_i = 2'(sel); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && busy_o != '0; k++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin commit[i] = '0; stage[i] = '0; fval[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(busy_o == '0, "R1", W'(busy_o), 0);
    chk(wr_err_o == 0, "R1", W'(wr_err_o), 0);
    for (int i = 0; i < N; i++) chk(sreg(i) == '0, "R1", sreg(i), 0);

    // R2 / R4: single write
    wr(0, 32'hA5A5_0001);
    chk(busy_o == 3'b001, "R4", W'(busy_o), 3'b001);
    wait_idle();
    chk(sreg(0) == 32'hA5A5_0001, "R2", sreg(0), 32'hA5A5_0001);

    // R6 / R7 / R8: frozen batch
    freeze_i = 1;
    wr(0, 32'h0000_D00D);
    wr(2, 32'h0000_E00E);
    wr(0, 32'h0000_F00F);
    repeat (60) @(negedge clk_i);
    chk(busy_o == 3'b101, "R6", W'(busy_o), 3'b101);
    chk(sreg(0) == 32'hA5A5_0001, "R6", sreg(0), 32'hA5A5_0001);
    chk(sreg(2) == 0, "R6", sreg(2), 0);
    chk(wr_err_o == 0, "R7", W'(wr_err_o), 0);
    freeze_i = 0;
    for (int k = 0; k < 100 && busy_o == 3'b101; k++) @(negedge clk_i);
    chk(busy_o == 3'b000, "R8", W'(busy_o), 0);
    chk(sreg(0) == 32'h0000_F00F, "R7", sreg(0), 32'h0000_F00F);
    chk(sreg(2) == 32'h0000_E00E, "R8", sreg(2), 32'h0000_E00E);

    // R9: no slow clock selected
    slow_clk_on_i = 0;
    wr(1, 32'h1234_5678);
    repeat (80) @(negedge clk_i);
    chk(busy_o[1] == 1, "R9", W'(busy_o[1]), 1);
    chk(sreg(1) == 0, "R9", sreg(1), 0);
    slow_clk_on_i = 1;
    wait_idle();
    chk(sreg(1) == 32'h1234_5678, "R9", sreg(1), 32'h1234_5678);

    // R11: select out of range
    tag = "R11";
    wr(3, 32'hDEAD_BEEF);
    repeat (10) @(negedge clk_i);
    chk(busy_o == 0, "R11", W'(busy_o), 0);
    chk(wr_err_o == 0, "R11", W'(wr_err_o), 0);
    tag = "R4";

    // R5: write to busy register
    wr(1, 32'h0000_0B0B);
    wr(1, 32'h0000_0C0C);
    chk(wr_err_o == 1, "R5", W'(wr_err_o), 1);
    wait_idle();
    chk(sreg(1) == 32'h0000_0B0B, "R5", sreg(1), 32'h0000_0B0B);

    // R10: sticky
    repeat (50) @(negedge clk_i);
    chk(wr_err_o == 1, "R10", W'(wr_err_o), 1);
    finish_run();
  end
endmodule